// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block sits between a bank of per-source interrupt state and one processor's interrupt input. Every clock it looks at all sources, keeps those that are both enabled and pending, and finds the most urgent one. A smaller priority value is more urgent. When two sources share the best value, the lower-numbered source wins. The winning source number is presented as the current pending ID. A single request line is raised toward the processor when that winner may preempt the work already in progress.

The request is gated in two stages.

- A global distribution enable and a processor-side enable must both be on.
- The winner's priority must not exceed the priority mask. A winner that fails this check is reported as the reserved "no interrupt" ID, 1023.
- Even when the ID is shown, the request line only rises if the winner is strictly more urgent than the current running priority.

The running priority and the mask are one bit wider than a source priority. This lets the idle running value of 0x100 admit every 8-bit priority. The surrounding logic holds the mask at 0xF0 out of reset.

The outputs are registered, so any change on the inputs reaches the ID and the request one clock later.

Top module: `pending_prio_sel`

## Requirements
- R1: A source is a candidate only when its bit in `src_enable` and its bit in `src_pending` are both 1. A source with only one of the two set never appears on `cur_id`.
- R2: Among candidates, the one with the numerically smallest priority wins. Source i's priority is `src_prio[i*8 +: 8]`.
- R3: When several candidates share the smallest priority, the lowest-numbered of them wins.
- R4: With no candidate, `cur_id` is 1023 and `irq_req` is 0.
- R5: If `dist_en` or `cpu_en` is 0, `cur_id` is 1023 and `irq_req` is 0, whatever the candidates.
- R6: If the winner's priority is greater than `prio_mask`, `cur_id` is 1023 and `irq_req` is 0. A priority equal to the mask passes.
- R7: When the winner passes the mask, `cur_id` shows it. `irq_req` is 1 only if the winner's priority is strictly less than `run_prio`.
- R8: With `run_prio` at the idle value 0x100 and `prio_mask` at 0x1FF, a winner of priority 0xFF raises `irq_req`.
- R9: Outputs are registered. A change on the inputs is visible one clock later. While `rst_n` is low, `cur_id` is 1023 and `irq_req` is 0.
- R10: The highest source, 95, is selected like any other when it is the sole candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | 1 | Processor-interface enable |
| src_enable | input | 96 | Per-source enable bits, bit i for source i |
| src_pending | input | 96 | Per-source pending bits, bit i for source i |
| src_prio | input | 768 | Per-source 8-bit priority, source i at bits i*8 +: 8 |
| prio_mask | input | 9 | Priority mask; winners above it are suppressed |
| run_prio | input | 9 | Priority of the interrupt currently running (0x100 when idle) |
| cur_id | output | 10 | Selected source, or 1023 when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench aims at the comparison boundaries, because each one is easy to get wrong in a visible way:

- A winner exactly at the mask must still be shown and requested. An off-by-one would drop it.
- A winner equal to the running priority must be shown but not requested. Using a non-strict compare there would raise a request that cannot preempt.
- Ties must go to the lower source number. Reversing the compare in the tree would report the higher source.
- Half-set sources, with only enable or only pending, must never be selected.
- Source 95 alone must be found. A short tree would miss the top leaf.

Long random runs with priorities drawn from a small set then keep ties and mask/running-priority equality frequent.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int PRIO_W  = 8;
    localparam int ID_W    = 10;
    localparam int LIMIT_W = PRIO_W + 1;
    localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [LIMIT_W-1:0] limit_t;
    typedef logic [ID_W-1:0]    id_t;

    typedef struct packed {
        logic  vld;
        prio_t prio;
        id_t   id;
    } cand_t;

    typedef struct packed {
        id_t  id;
        logic req;
    } out_t;
endpackage

// File: rtl/pps_leaf.sv
module pps_leaf
    import pps_pkg::*;
#(
    parameter int SRC_ID = 0
) (
    input  logic  en,
    input  logic  pend,
    input  prio_t prio,
    output cand_t cand
);
    always_comb begin
        cand.vld  = en & pend;
        cand.prio = prio;
        cand.id   = id_t'(SRC_ID);
    end
endmodule

// File: rtl/pps_pick.sv
module pps_pick
    import pps_pkg::*;
(
    input  cand_t lo,
    input  cand_t hi,
    output cand_t win
);
    logic take_hi;

    always_comb begin
        // lo covers the lower source numbers; hi only wins when strictly more urgent
        take_hi = hi.vld && (!lo.vld || (hi.prio < lo.prio));
        win     = take_hi ? hi : lo;
    end
endmodule

// File: rtl/pps_tree.sv
module pps_tree
    import pps_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output cand_t                     best
);
    localparam int LVLS  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int NLEAF = 1 << LVLS;

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int WIDTH = NLEAF >> l;
        cand_t node [WIDTH];

        if (l == 0) begin : g_leaves
            for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
                if (i < NUM_SRC) begin : g_real
                    pps_leaf #(.SRC_ID(i)) u_leaf (
                        .en   (en[i]),
                        .pend (pend[i]),
                        .prio (prio[i*PRIO_W +: PRIO_W]),
                        .cand (node[i])
                    );
                end else begin : g_pad
                    pps_leaf #(.SRC_ID(i)) u_leaf (
                        .en   (1'b0),
                        .pend (1'b0),
                        .prio ({PRIO_W{1'b1}}),
                        .cand (node[i])
                    );
                end
            end
        end else begin : g_merge
            for (genvar k = 0; k < WIDTH; k++) begin : g_node
                pps_pick u_pick (
                    .lo  (g_lvl[l-1].node[2*k]),
                    .hi  (g_lvl[l-1].node[2*k+1]),
                    .win (node[k])
                );
            end
        end
    end

    assign best = g_lvl[LVLS].node[0];
endmodule

// File: rtl/pending_prio_sel.sv
module pending_prio_sel
    import pps_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dist_en,
    input  logic                      cpu_en,
    input  logic [NUM_SRC-1:0]        src_enable,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [LIMIT_W-1:0]        prio_mask,
    input  logic [LIMIT_W-1:0]        run_prio,
    output logic [ID_W-1:0]           cur_id,
    output logic                      irq_req
);
    cand_t  best;
    out_t   out_d, out_q;
    limit_t best_ext;

    pps_tree #(.NUM_SRC(NUM_SRC)) u_tree (
        .en   (src_enable),
        .pend (src_pending),
        .prio (src_prio),
        .best (best)
    );

    always_comb begin
        best_ext  = {1'b0, best.prio};
        out_d.id  = SPUR_ID;
        out_d.req = 1'b0;
        if (dist_en && cpu_en && best.vld && (best_ext <= prio_mask)) begin
            out_d.id  = best.id;
            out_d.req = (best_ext < run_prio);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.id  <= SPUR_ID;
            out_q.req <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cur_id  = out_q.id;
    assign irq_req = out_q.req;
endmodule

// File: rtl/pending_prio_sel_chk.sv
module pending_prio_sel_chk
    import pps_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dist_en,
    input logic                      cpu_en,
    input logic [NUM_SRC-1:0]        src_enable,
    input logic [NUM_SRC-1:0]        src_pending,
    input logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input logic [LIMIT_W-1:0]        prio_mask,
    input logic [LIMIT_W-1:0]        run_prio,
    input logic [ID_W-1:0]           cur_id,
    input logic                      irq_req
);
    assert_req_has_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cur_id != SPUR_ID));

    assert_no_cand_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_enable & src_pending) == '0) |=> (cur_id == SPUR_ID && !irq_req));

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dist_en || !cpu_en) |=> (cur_id == SPUR_ID && !irq_req));

    assert_run_zero_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == '0) |=> !irq_req);

    assert_id_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_id != SPUR_ID) |-> (int'(cur_id) < NUM_SRC));
endmodule

bind pending_prio_sel pending_prio_sel_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/pending_prio_sel_tb.sv
module pending_prio_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dist_en = 1'b0;
    logic          cpu_en = 1'b0;
    logic [N-1:0]  src_enable = '0;
    logic [N-1:0]  src_pending = '0;
    logic [N*8-1:0] src_prio = '0;
    logic [8:0]    prio_mask = 9'h0F0;
    logic [8:0]    run_prio = 9'h100;
    logic [9:0]    cur_id;
    logic          irq_req;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pending_prio_sel #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .src_enable(src_enable), .src_pending(src_pending), .src_prio(src_prio),
        .prio_mask(prio_mask), .run_prio(run_prio),
        .cur_id(cur_id), .irq_req(irq_req)
    );

    task automatic model(output int eid, output bit ereq);
        int best_p = 256;
        int best_i = -1;
        for (int i = 0; i < N; i++) begin
            if (src_enable[i] && src_pending[i] && int'(src_prio[i*8 +: 8]) < best_p) begin
                best_p = int'(src_prio[i*8 +: 8]);
                best_i = i;
            end
        end
        eid = 1023;
        ereq = 1'b0;
        if (dist_en && cpu_en && best_i >= 0 && best_p <= int'(prio_mask)) begin
            eid = best_i;
            ereq = (best_p < int'(run_prio));
        end
    endtask

    task automatic compare(string tag, int eid, bit ereq);
        vectors++;
        if (int'(cur_id) != eid || irq_req != ereq) begin
            misses++;
            $display("FAIL %s: cur_id=%0d irq_req=%0b expected cur_id=%0d irq_req=%0b",
                     tag, cur_id, irq_req, eid, ereq);
        end
    endtask

    // Inputs are set between edges; the outputs show them after the next rising edge (R9).
    task automatic cyc(string tag);
        int eid;
        bit ereq;
        model(eid, ereq);
        @(posedge clk);
        #1;
        compare(tag, eid, ereq);
    endtask

    task automatic clear_src();
        src_enable = '0;
        src_pending = '0;
        src_prio = '0;
    endtask

    task automatic set_src(int i, logic [7:0] p);
        src_enable[i] = 1'b1;
        src_pending[i] = 1'b1;
        src_prio[i*8 +: 8] = p;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R9: reset values, with an active candidate applied during reset
        dist_en = 1'b1; cpu_en = 1'b1;
        set_src(4, 8'h10);
        repeat (3) @(posedge clk);
        #1;
        compare("R9 reset", 1023, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_src();
        prio_mask = 9'h0F0; run_prio = 9'h100;

        cyc("R4 no candidate");

        // R1: half-set sources are never candidates
        src_pending[5] = 1'b1; src_prio[5*8 +: 8] = 8'h01;
        src_enable[6]  = 1'b1; src_prio[6*8 +: 8] = 8'h01;
        cyc("R1 half set");
        set_src(7, 8'h50);
        cyc("R1 full set");

        // R2: lower value wins over lower index
        clear_src();
        set_src(3, 8'h80); set_src(10, 8'h40);
        cyc("R2 urgency");

        // R3: tie goes to lower index
        clear_src();
        set_src(40, 8'h30); set_src(20, 8'h30);
        cyc("R3 tie");

        // R5: enables
        dist_en = 1'b0; cyc("R5 dist off");
        dist_en = 1'b1; cpu_en = 1'b0; cyc("R5 cpu off");
        cpu_en = 1'b1; cyc("R5 both on");

        // R6: mask boundary
        prio_mask = 9'h030; cyc("R6 mask equal");
        prio_mask = 9'h02F; cyc("R6 mask below");
        prio_mask = 9'h0F0;

        // R7: running priority boundary
        run_prio = 9'h030; cyc("R7 run equal");
        run_prio = 9'h031; cyc("R7 run above");
        run_prio = 9'h000; cyc("R7 run zero");

        // R8: idle running priority admits 0xFF
        clear_src();
        set_src(12, 8'hFF);
        prio_mask = 9'h1FF; run_prio = 9'h100;
        cyc("R8 idle preempt");

        // R10: top source
        clear_src();
        set_src(95, 8'h77);
        cyc("R10 top source");
        src_prio[95*8 +: 8] = 8'h00;
        cyc("R10 top source prio0");

        // Random mixing; priorities from a small set to force ties and boundaries (R2, R3)
        for (int t = 0; t < 3000; t++) begin
            int dens = (t / 500) % 3;
            for (int i = 0; i < N; i++) begin
                src_enable[i]  = ($urandom % 4) <= dens;
                src_pending[i] = ($urandom % 4) <= dens;
                src_prio[i*8 +: 8] = 8'(($urandom % 8) * 32 + ($urandom % 2));
            end
            dist_en   = ($urandom % 16) != 0;
            cpu_en    = ($urandom % 16) != 0;
            prio_mask = 9'(($urandom % 9) * 32 + ($urandom % 2));
            run_prio  = ($urandom % 4 == 0) ? 9'h100 : 9'(($urandom % 8) * 32 + ($urandom % 2));
            cyc("R2 R3 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule